// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Select

This block is the digital division section of an integer-N frequency synthesizer. It has two event inputs. Each is a one-cycle strobe that marks one edge of the local-oscillator signal or of the reference clock, sampled in the system clock domain.

The local-oscillator events first pass through a fixed divide-by-two stage. The output of that stage drives a programmable 9-bit main divider. The reference events pass through a divider whose ratio is picked from 8, 11, 22 or 44. Each divider produces a waveform output and a one-cycle tick at the end of every full division cycle. The ticks are the events a phase detector would compare. Ratios are applied only at division-cycle boundaries, so no runt cycle is ever produced.

A 2-bit test select places one signal on a shared status output: the external lock indication, the reference divider waveform, the divide-by-two waveform or the main divider waveform. The same select also gates the enables of the I and Q transmit mixers.

Top module: `synth_divchain`

## Requirements
- R1: The reference ratio select maps 00 to 8, 01 to 11, 10 to 22 and 11 to 44. One `ref_tick` is produced for that many `ref_evt` strobes.
- R2: After reset, the first reference division cycle uses ratio 22 and the first main division cycle uses ratio 352, whatever the ratio inputs hold.
- R3: Local-oscillator events are divided by two before the main divider. The prescaler state starts low after reset and toggles on every `lo_evt`. The main divider advances on each `lo_evt` that finds the prescaler state high, so one `main_tick` follows every 2×N `lo_evt` strobes.
- R4: `main_ratio` is unsigned binary. Any value below 64 is used as 64.
- R5: In both dividers, the event that completes a division cycle raises the tick for exactly one clock, one cycle later, and drives the waveform low at the same time. Within a cycle of ratio N, the waveform is high once the in-cycle count (0 to N−1) has reached floor(N/2).
- R6: A ratio input is sampled only in the cycle of the event that completes the current division cycle. Changes made at any other time have no effect on the current division cycle.
- R7: `test_sel` = 00 places `lock_in` on `status_out`, with both `imix_en` and `qmix_en` high.
- R8: `test_sel` = 01 (bit 0 set) places the reference divider waveform on `status_out`, with `qmix_en` low and `imix_en` high.
- R9: `test_sel` = 10 (bit 1 set) places the divide-by-two prescaler state on `status_out`, with `imix_en` low and `qmix_en` high.
- R10: `test_sel` = 11 places the main divider waveform on `status_out` and drives both mixer enables low.
- R11: `status_out`, `imix_en` and `qmix_en` are registered. They reflect their inputs one clock later. In reset they are 0, 1 and 1; `ref_wave`, `ref_tick`, `main_wave` and `main_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_evt | input | 1 | One-cycle strobe per local-oscillator edge |
| ref_evt | input | 1 | One-cycle strobe per reference-clock edge |
| ref_sel | input | 2 | Reference ratio select |
| main_ratio | input | 9 | Main divider ratio |
| test_sel | input | 2 | Status source and mixer gating select |
| lock_in | input | 1 | Lock indication from the phase detector |
| ref_wave | output | 1 | Reference divider waveform |
| ref_tick | output | 1 | Reference division-cycle end strobe |
| main_wave | output | 1 | Main divider waveform |
| main_tick | output | 1 | Main division-cycle end strobe |
| status_out | output | 1 | Selected status signal |
| imix_en | output | 1 | I transmit mixer enable |
| qmix_en | output | 1 | Q transmit mixer enable |

## Verification
A divider's tick and waveform respond one clock after the clock edge that samples the completing event. The mixer enables and `status_out` respond one clock after `test_sel`, `lock_in` or the selected waveform changes. The bench applies every input at a falling edge and steps its own reference model at the next rising edge. It then compares all seven outputs at the following falling edge, so each result is checked in exactly the cycle it is due. Separate counts of reference and local-oscillator strobes up to the first ticks after reset confirm the default ratios of 22 and 704.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  localparam int REF_SEL_W  = 2;
  localparam int REF_CNT_W  = 6;
  localparam int MAIN_W     = 9;
  localparam int MAIN_MIN   = 64;
  localparam int MAIN_DEF   = 352;
  localparam logic [REF_SEL_W-1:0] REF_SEL_DEF = 2'b10;

  typedef enum logic [1:0] {
    TST_LOCK = 2'b00,
    TST_REF  = 2'b01,
    TST_PRE  = 2'b10,
    TST_MAIN = 2'b11
  } tst_sel_e;

  function automatic logic [REF_CNT_W-1:0] ref_ratio_of(input logic [REF_SEL_W-1:0] sel);
    case (sel)
      2'b00:   return REF_CNT_W'(8);
      2'b01:   return REF_CNT_W'(11);
      2'b10:   return REF_CNT_W'(22);
      default: return REF_CNT_W'(44);
    endcase
  endfunction

  function automatic logic [MAIN_W-1:0] main_ratio_of(input logic [MAIN_W-1:0] raw);
    if (raw < MAIN_W'(MAIN_MIN)) return MAIN_W'(MAIN_MIN);
    return raw;
  endfunction

endpackage

// File: rtl/synth_prescale2.sv
module synth_prescale2 (
  input  logic clk,
  input  logic rst,
  input  logic evt_in,
  output logic half_state,
  output logic adv_out
);

  logic ph_q;

  always_ff @(posedge clk) begin
    if (rst)         ph_q <= 1'b0;
    else if (evt_in) ph_q <= ~ph_q;
  end

  assign half_state = ph_q;
  assign adv_out    = evt_in & ph_q;

  // R3: an advance is followed by the prescaler returning low
  assert_half_rate_R3: assert property (@(posedge clk) disable iff (rst)
    adv_out |=> !half_state);

endmodule

// File: rtl/synth_evt_div.sv
module synth_evt_div #(
  parameter int W         = 9,
  parameter int DEF_RATIO = 352,
  parameter int MIN_RATIO = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] ratio_in,
  output logic         div_out,
  output logic         tick
);

  localparam logic [W-1:0] DEF_V = W'(DEF_RATIO);
  localparam logic [W-1:0] MIN_V = W'(MIN_RATIO);

  logic [W-1:0] cnt_q;
  logic [W-1:0] ratio_q;
  logic [W-1:0] cnt_nxt;
  logic         last_w;
  logic         out_q;
  logic         tick_q;

  assign cnt_nxt = cnt_q + W'(1);
  assign last_w  = (cnt_q == ratio_q - W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= DEF_V;
      out_q   <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (adv) begin
        if (last_w) begin
          cnt_q   <= '0;
          ratio_q <= ratio_in;
          out_q   <= 1'b0;
          tick_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_nxt;
          out_q <= (cnt_nxt >= (ratio_q >> 1));
        end
      end
    end
  end

  assign div_out = out_q;
  assign tick    = tick_q;

  // R5: the in-cycle count never reaches the active ratio
  assert_count_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q < ratio_q);

  // R5: a tick always coincides with the waveform low
  assert_tick_low_R5: assert property (@(posedge clk) disable iff (rst)
    tick |-> !div_out);

  // R6: the active ratio changes only together with a tick
  assert_ratio_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_q) |-> tick);

  // R4: the active ratio never falls below its floor
  assert_ratio_floor_R4: assert property (@(posedge clk) disable iff (rst)
    ratio_q >= MIN_V);

endmodule

// File: rtl/synth_test_mux.sv
module synth_test_mux
  import synth_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       lock_in,
  input  logic       ref_wave,
  input  logic       pre_wave,
  input  logic       main_wave,
  output logic       status_out,
  output logic       imix_en,
  output logic       qmix_en
);

  logic st_d, ie_d, qe_d;
  logic st_q, ie_q, qe_q;

  always_comb begin
    case (tst_sel_e'(sel))
      TST_REF:  begin st_d = ref_wave;  ie_d = 1'b1; qe_d = 1'b0; end
      TST_PRE:  begin st_d = pre_wave;  ie_d = 1'b0; qe_d = 1'b1; end
      TST_MAIN: begin st_d = main_wave; ie_d = 1'b0; qe_d = 1'b0; end
      default:  begin st_d = lock_in;   ie_d = 1'b1; qe_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= 1'b0;
      ie_q <= 1'b1;
      qe_q <= 1'b1;
    end else begin
      st_q <= st_d;
      ie_q <= ie_d;
      qe_q <= qe_d;
    end
  end

  assign status_out = st_q;
  assign imix_en    = ie_q;
  assign qmix_en    = qe_q;

  // R10: select 11 turns both mixers off on the next cycle
  assert_both_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == 2'b11) |-> (!imix_en && !qmix_en));

  // R7: select 00 passes the lock indication with both mixers on
  assert_lock_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == 2'b00) |-> (imix_en && qmix_en && status_out == $past(lock_in)));

endmodule

// File: rtl/synth_divchain.sv
module synth_divchain
  import synth_div_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lo_evt,
  input  logic                 ref_evt,
  input  logic [REF_SEL_W-1:0] ref_sel,
  input  logic [MAIN_W-1:0]    main_ratio,
  input  logic [1:0]           test_sel,
  input  logic                 lock_in,
  output logic                 ref_wave,
  output logic                 ref_tick,
  output logic                 main_wave,
  output logic                 main_tick,
  output logic                 status_out,
  output logic                 imix_en,
  output logic                 qmix_en
);

  localparam int REF_DEF = 22;
  localparam int REF_MIN = 8;

  logic                 pre_state;
  logic                 main_adv;
  logic [REF_CNT_W-1:0] ref_ratio_w;
  logic [MAIN_W-1:0]    main_ratio_w;

  assign ref_ratio_w  = ref_ratio_of(ref_sel);
  assign main_ratio_w = main_ratio_of(main_ratio);

  synth_prescale2 u_pre (
    .clk        (clk),
    .rst        (rst),
    .evt_in     (lo_evt),
    .half_state (pre_state),
    .adv_out    (main_adv)
  );

  synth_evt_div #(
    .W         (REF_CNT_W),
    .DEF_RATIO (REF_DEF),
    .MIN_RATIO (REF_MIN)
  ) u_ref_div (
    .clk      (clk),
    .rst      (rst),
    .adv      (ref_evt),
    .ratio_in (ref_ratio_w),
    .div_out  (ref_wave),
    .tick     (ref_tick)
  );

  synth_evt_div #(
    .W         (MAIN_W),
    .DEF_RATIO (MAIN_DEF),
    .MIN_RATIO (MAIN_MIN)
  ) u_main_div (
    .clk      (clk),
    .rst      (rst),
    .adv      (main_adv),
    .ratio_in (main_ratio_w),
    .div_out  (main_wave),
    .tick     (main_tick)
  );

  synth_test_mux u_mux (
    .clk        (clk),
    .rst        (rst),
    .sel        (test_sel),
    .lock_in    (lock_in),
    .ref_wave   (ref_wave),
    .pre_wave   (pre_state),
    .main_wave  (main_wave),
    .status_out (status_out),
    .imix_en    (imix_en),
    .qmix_en    (qmix_en)
  );

  // R1: a reference tick is never raised without a preceding reference event
  assert_ref_tick_cause_R1: assert property (@(posedge clk) disable iff (rst)
    ref_tick |-> $past(ref_evt));

  // R3: a main tick is never raised without a preceding local-oscillator event
  assert_main_tick_cause_R3: assert property (@(posedge clk) disable iff (rst)
    main_tick |-> $past(lo_evt));

endmodule

// File: tb/synth_divchain_tb.sv
module synth_divchain_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lo_evt = 1'b0, ref_evt = 1'b0, lock_in = 1'b0;
  logic [1:0] ref_sel = 2'b00, test_sel = 2'b00;
  logic [8:0] main_ratio = 9'd0;
  logic       ref_wave, ref_tick, main_wave, main_tick, status_out, imix_en, qmix_en;

  int errors = 0, checks = 0;
  bit done = 0;

  int m_rcnt, m_rratio, m_mcnt, m_mratio;
  bit m_rout, m_rtick, m_mout, m_mtick, m_ph, m_st, m_ie, m_qe;
  int ref_seen, lo_seen;
  bit ref_first, main_first;

  always #5 clk = ~clk;

  synth_divchain u_dut (
    .clk(clk), .rst(rst), .lo_evt(lo_evt), .ref_evt(ref_evt),
    .ref_sel(ref_sel), .main_ratio(main_ratio), .test_sel(test_sel),
    .lock_in(lock_in), .ref_wave(ref_wave), .ref_tick(ref_tick),
    .main_wave(main_wave), .main_tick(main_tick), .status_out(status_out),
    .imix_en(imix_en), .qmix_en(qmix_en)
  );

  function automatic int exp_ref(input logic [1:0] s);
    case (s)
      2'b00: return 8;
      2'b01: return 11;
      2'b10: return 22;
      default: return 44;
    endcase
  endfunction

  function automatic int exp_main(input logic [8:0] r);
    return (r < 9'd64) ? 64 : int'(r);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rcnt = 0; m_rratio = 22; m_mcnt = 0; m_mratio = 352;
    m_rout = 0; m_rtick = 0; m_mout = 0; m_mtick = 0; m_ph = 0;
    m_st = 0; m_ie = 1; m_qe = 1;
  endtask

  task automatic model_step();
    bit madv;
    case (test_sel)
      2'b00: begin m_st = lock_in; m_ie = 1; m_qe = 1; end
      2'b01: begin m_st = m_rout;  m_ie = 1; m_qe = 0; end
      2'b10: begin m_st = m_ph;    m_ie = 0; m_qe = 1; end
      default: begin m_st = m_mout; m_ie = 0; m_qe = 0; end
    endcase
    m_rtick = 0;
    if (ref_evt) begin
      if (m_rcnt == m_rratio - 1) begin
        m_rcnt = 0; m_rratio = exp_ref(ref_sel); m_rout = 0; m_rtick = 1;
      end else begin
        m_rcnt++; m_rout = (m_rcnt >= m_rratio / 2);
      end
    end
    madv = lo_evt && m_ph;
    if (lo_evt) m_ph = !m_ph;
    m_mtick = 0;
    if (madv) begin
      if (m_mcnt == m_mratio - 1) begin
        m_mcnt = 0; m_mratio = exp_main(main_ratio); m_mout = 0; m_mtick = 1;
      end else begin
        m_mcnt++; m_mout = (m_mcnt >= m_mratio / 2);
      end
    end
  endtask

  task automatic compare_all();
    chk("R1/R5 ref_tick", ref_tick, m_rtick);
    chk("R5 ref_wave", ref_wave, m_rout);
    chk("R3/R4 main_tick", main_tick, m_mtick);
    chk("R5/R6 main_wave", main_wave, m_mout);
    case (test_sel)
      2'b00: chk("R7 status", status_out, m_st);
      2'b01: chk("R8 status", status_out, m_st);
      2'b10: chk("R9 status", status_out, m_st);
      default: chk("R10 status", status_out, m_st);
    endcase
    chk("R11 imix_en", imix_en, m_ie);
    chk("R11 qmix_en", qmix_en, m_qe);
  endtask

  task automatic cycle();
    @(posedge clk);
    if (ref_evt && !ref_first) ref_seen++;
    if (lo_evt && !main_first) lo_seen++;
    model_step();
    @(negedge clk);
    compare_all();
    if (ref_tick && !ref_first) begin
      ref_first = 1; chk("R2 first ref cycle", ref_seen, 22);
    end
    if (main_tick && !main_first) begin
      main_first = 1; chk("R2 first main cycle", lo_seen, 704);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R11 reset status", status_out, 0);
    chk("R11 reset imix", imix_en, 1);
    chk("R11 reset qmix", qmix_en, 1);
    chk("R11 reset ticks", {ref_tick, main_tick, ref_wave, main_wave}, 0);
    // R2: inputs disagree with defaults during the first cycles
    ref_sel = 2'b00; main_ratio = 9'd100;
    rst = 1'b0;
    ref_evt = 1'b1; lo_evt = 1'b1;
    repeat (720) cycle();
    // R4: sub-minimum main ratio, every test select, directed
    main_ratio = 9'd5;
    for (int s = 0; s < 4; s++) begin
      test_sel = 2'(s);
      repeat (200) cycle();
    end
    for (int k = 0; k < 30000; k++) begin
      ref_evt = ($urandom_range(1, 0) == 1);
      lo_evt  = ($urandom_range(3, 0) != 0);
      lock_in = ($urandom_range(1, 0) == 1);
      if ($urandom_range(49, 0) == 0) test_sel = 2'($urandom_range(3, 0));
      if ($urandom_range(299, 0) == 0) ref_sel = 2'($urandom_range(3, 0));
      if ($urandom_range(299, 0) == 0) begin
        case ($urandom_range(7, 0))
          0: main_ratio = 9'($urandom_range(63, 0));
          1: main_ratio = 9'd511;
          2: main_ratio = 9'd64;
          default: main_ratio = 9'($urandom_range(200, 64));
        endcase
      end
      cycle();
    end
    chk("R1 ref divider ran", int'(ref_first), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule